// File: doc/BRIEF.md
# Prioritised Interrupt Level Evaluator

This block decides which interrupt level the processor should take next. Four kinds of source compete, in a fixed order. The first is a halt pin. The second is a pending clock tick. The third is a set of four hardware request lines, each gated by a programmable mask. The last is a 15-level software request summary. A source only counts when its level is above the processor's current level; the halt pin is the exception and always counts. The winning level is recomputed every cycle and presented from a register. A value of zero means nothing is pending.

When the processor takes an interrupt, it acknowledges the level it took on a separate port. The block answers with a 10-bit vector on the next cycle.
- A clock acknowledge returns a fixed timer vector and retires the clock request.
- A hardware acknowledge returns a vector read from an eight-entry table that software loads. The entry used depends on which unmasked line has the highest priority.
- An acknowledge above the top hardware level is flagged as an error.

The hardware request register and the mask register are read and written through a small register port. Each register answers at two addresses.

Top module: `ilv_eval`

## Requirements
- R1: While `halt_pin` is high, `win_lvl` is 31 on the following cycle, whatever else is pending and whatever `cur_lvl` is.
- R2: With no halt, a pending clock request gives `win_lvl` = 22, but only when `cur_lvl` < 22. The clock request outranks hardware and software requests.
- R3: With no halt and no eligible clock, `win_lvl` is 20 when `cur_lvl` < 20 and the request register ANDed with the mask register is non-zero. Hardware outranks software.
- R4: Software requests are considered only when `cur_lvl` < 15. Among the bits of `sw_summary` with an index above `cur_lvl`, the highest index is the level. Bit 0 is never eligible. With no winner at all, `win_lvl` is 0.
- R5: `win_lvl` is a register. It reflects the inputs and the register state of the previous cycle, and it is 0 after reset.
- R6: The request register is addressed by `reg_addr` 0 and 2, and the mask register by 1 and 3 (bit 0 of the address selects the mask).
  - A `hw_set` bit sets the matching request bit.
  - A write to the request register clears the bits written as one. A set arriving in the same cycle wins over the clear.
  - A write to the mask register replaces it.
  - A read returns the 4-bit value on `reg_rdata` one cycle later.
- R7: An acknowledge at level 22 returns vector 0x0C0 and clears the clock request, unless a new tick arrives in the same cycle.
- R8: An acknowledge at any level up to 23 other than 22 returns a vector for the highest-numbered unmasked hardware line.
  - Line 3 uses table entry 7, line 2 uses entry 6, line 1 uses entry 4 and line 0 uses entry 1.
  - The vector is the low 10 bits of that entry.
  - If no line is unmasked, the vector is 0.
- R9: An acknowledge at a level above 23 sets `ack_err` for one cycle and returns vector 0.
- R10: The vector table has 8 entries of 16 bits, written through `vt_wr`/`vt_idx`/`vt_wdata`.
- R11: A `clk_tick` pulse makes the clock request pending, and it stays pending until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_pin | input | 1 | Halt request, highest priority |
| clk_tick | input | 1 | Pulse that makes the clock request pending |
| hw_set | input | 4 | Pulses that set hardware request bits |
| sw_summary | input | 16 | Software request summary, bit n = level n |
| cur_lvl | input | 5 | Current processor level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (bit 0: mask, else request) |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data, one cycle after `reg_rd` |
| vt_wr | input | 1 | Vector table write strobe |
| vt_idx | input | 3 | Vector table entry index |
| vt_wdata | input | 16 | Vector table write data |
| ack_req | input | 1 | Acknowledge strobe |
| ack_lvl | input | 5 | Level being acknowledged |
| ack_vec | output | 10 | Vector for the acknowledged level |
| ack_err | output | 1 | Acknowledge level above hardware maximum |
| win_lvl | output | 5 | Highest eligible pending level, 0 for none |

## Verification
The level output is driven with each source alone, and then with pairs of sources that expose the priority order: halt over clock, clock over hardware, and hardware over software. Software patterns place bits just above, exactly at and below the current level, set bit 0 alone, and hold the current level at 15. Together these separate an "above" comparison from an "at or above" one. Hardware requests are tried with the mask partly closed, and at alias addresses, to tell mask gating apart from raw requests. The acknowledge tests step through each source in turn with distinct table contents, whose upper bits are set, so that a wrong slot mapping or a missing 10-bit truncation shows up.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_CLK  = 2'd1,
    ACK_HW   = 2'd2,
    ACK_ERR  = 2'd3
  } ack_kind_t;

  // table slot used by each hardware source
  function automatic logic [2:0] hw_slot(input logic [1:0] src);
    case (src)
      2'd0:    hw_slot = 3'd1;
      2'd1:    hw_slot = 3'd4;
      2'd2:    hw_slot = 3'd6;
      default: hw_slot = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/ilv_req_regs.sv
module ilv_req_regs #(
  parameter int HW_N = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HW_N-1:0] hw_set,
  input  logic            clk_tick,
  input  logic            clk_clr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [HW_N-1:0] reg_wdata,
  output logic [HW_N-1:0] req_q,
  output logic [HW_N-1:0] mask_q,
  output logic            clk_pend,
  output logic [HW_N-1:0] reg_rdata
);

  logic sel_mask;
  assign sel_mask = reg_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      mask_q    <= '0;
      clk_pend  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && !sel_mask) req_q <= (req_q & ~reg_wdata) | hw_set;
      else                     req_q <= req_q | hw_set;
      if (reg_wr && sel_mask)  mask_q <= reg_wdata;
      clk_pend <= clk_tick | (clk_pend & ~clk_clr);
      if (reg_rd) reg_rdata <= sel_mask ? mask_q : req_q;
    end
  end

endmodule

// File: rtl/ilv_prio.sv
module ilv_prio #(
  parameter int LVL_W    = 5,
  parameter int SW_MAX   = 15,
  parameter int LVL_HALT = 31,
  parameter int LVL_CLK  = 22,
  parameter int LVL_HW   = 20
) (
  input  logic              halt_pin,
  input  logic              clk_pend,
  input  logic              hw_any,
  input  logic [SW_MAX:0]   sw_sum,
  input  logic [LVL_W-1:0]  cur,
  output logic [LVL_W-1:0]  lvl
);

  localparam logic [LVL_W-1:0] L_HALT = LVL_W'(LVL_HALT);
  localparam logic [LVL_W-1:0] L_CLK  = LVL_W'(LVL_CLK);
  localparam logic [LVL_W-1:0] L_HW   = LVL_W'(LVL_HW);

  logic [LVL_W-1:0] sw_best;

  // highest software bit strictly above the current level (implies cur < SW_MAX)
  always_comb begin
    sw_best = '0;
    for (int i = 1; i <= SW_MAX; i++) begin
      if (sw_sum[i] && (i > int'(cur))) sw_best = LVL_W'(i);
    end
  end

  always_comb begin
    if (halt_pin)                   lvl = L_HALT;
    else if (clk_pend && cur < L_CLK) lvl = L_CLK;
    else if (hw_any && cur < L_HW)  lvl = L_HW;
    else                            lvl = sw_best;
  end

endmodule

// File: rtl/ilv_vec_table.sv
module ilv_vec_table #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/ilv_eval.sv
module ilv_eval
  import ilv_pkg::*;
#(
  parameter int LVL_W     = 5,
  parameter int HW_N      = 4,
  parameter int SW_MAX    = 15,
  parameter int LVL_HALT  = 31,
  parameter int LVL_CLK   = 22,
  parameter int LVL_HW    = 20,
  parameter int LVL_HMAX  = 23,
  parameter int VT_DEPTH  = 8,
  parameter int VT_DW     = 16,
  parameter int VEC_W     = 10,
  parameter int TIMER_VEC = 'h0C0,
  localparam int VT_AW    = $clog2(VT_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_pin,
  input  logic             clk_tick,
  input  logic [HW_N-1:0]  hw_set,
  input  logic [SW_MAX:0]  sw_summary,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [HW_N-1:0]  reg_wdata,
  output logic [HW_N-1:0]  reg_rdata,
  input  logic             vt_wr,
  input  logic [VT_AW-1:0] vt_idx,
  input  logic [VT_DW-1:0] vt_wdata,
  input  logic             ack_req,
  input  logic [LVL_W-1:0] ack_lvl,
  output logic [VEC_W-1:0] ack_vec,
  output logic             ack_err,
  output logic [LVL_W-1:0] win_lvl
);

  localparam logic [LVL_W-1:0] L_CLK  = LVL_W'(LVL_CLK);
  localparam logic [LVL_W-1:0] L_HMAX = LVL_W'(LVL_HMAX);

  logic [HW_N-1:0]  req_q, mask_q, hw_act;
  logic             clk_pend, clk_clr, hw_hit;
  logic [1:0]       hw_top;
  logic [LVL_W-1:0] lvl_next;
  logic [VT_DW-1:0] vt_q;
  ack_kind_t        kind_q;

  assign clk_clr = ack_req && (ack_lvl == L_CLK);

  ilv_req_regs #(.HW_N(HW_N)) u_regs (
    .clk(clk), .rst(rst), .hw_set(hw_set), .clk_tick(clk_tick),
    .clk_clr(clk_clr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .req_q(req_q),
    .mask_q(mask_q), .clk_pend(clk_pend), .reg_rdata(reg_rdata)
  );

  assign hw_act = req_q & mask_q;
  assign hw_hit = |hw_act;

  // highest numbered active source wins
  always_comb begin
    hw_top = '0;
    for (int i = 0; i < HW_N; i++) begin
      if (hw_act[i]) hw_top = 2'(i);
    end
  end

  ilv_prio #(
    .LVL_W(LVL_W), .SW_MAX(SW_MAX), .LVL_HALT(LVL_HALT),
    .LVL_CLK(LVL_CLK), .LVL_HW(LVL_HW)
  ) u_prio (
    .halt_pin(halt_pin), .clk_pend(clk_pend), .hw_any(hw_hit),
    .sw_sum(sw_summary), .cur(cur_lvl), .lvl(lvl_next)
  );

  ilv_vec_table #(.DEPTH(VT_DEPTH), .DW(VT_DW)) u_vt (
    .clk(clk), .wr_en(vt_wr), .wr_idx(vt_idx), .wr_data(vt_wdata),
    .rd_en(ack_req), .rd_idx(VT_AW'(hw_slot(hw_top))), .rd_data(vt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_lvl <= '0;
      kind_q  <= ACK_NONE;
    end else begin
      win_lvl <= lvl_next;
      if (!ack_req)               kind_q <= ACK_NONE;
      else if (ack_lvl > L_HMAX)  kind_q <= ACK_ERR;
      else if (ack_lvl == L_CLK)  kind_q <= ACK_CLK;
      else if (hw_hit)            kind_q <= ACK_HW;
      else                        kind_q <= ACK_NONE;
    end
  end

  always_comb begin
    case (kind_q)
      ACK_CLK: ack_vec = VEC_W'(TIMER_VEC);
      ACK_HW:  ack_vec = vt_q[VEC_W-1:0];
      default: ack_vec = '0;
    endcase
  end
  assign ack_err = (kind_q == ACK_ERR);

endmodule

// File: rtl/ilv_eval_chk.sv
module ilv_eval_chk #(
  parameter int LVL_W     = 5,
  parameter int VEC_W     = 10,
  parameter int LVL_HALT  = 31,
  parameter int LVL_CLK   = 22,
  parameter int LVL_HMAX  = 23,
  parameter int TIMER_VEC = 'h0C0
) (
  input logic             clk,
  input logic             rst,
  input logic             halt_pin,
  input logic             clk_tick,
  input logic             clk_pend,
  input logic [LVL_W-1:0] cur_lvl,
  input logic             ack_req,
  input logic [LVL_W-1:0] ack_lvl,
  input logic [VEC_W-1:0] ack_vec,
  input logic             ack_err,
  input logic [LVL_W-1:0] win_lvl
);

  a_r1_halt_level: assert property (@(posedge clk) disable iff (rst)
    halt_pin |=> win_lvl == LVL_W'(LVL_HALT));

  a_r2_clock_level: assert property (@(posedge clk) disable iff (rst)
    (!halt_pin && clk_pend && cur_lvl < LVL_W'(LVL_CLK)) |=> win_lvl == LVL_W'(LVL_CLK));

  a_r4_above_current: assert property (@(posedge clk) disable iff (rst)
    !halt_pin |=> (win_lvl == '0 || win_lvl > $past(cur_lvl)));

  a_r7_clock_ack: assert property (@(posedge clk) disable iff (rst)
    (ack_req && ack_lvl == LVL_W'(LVL_CLK) && !clk_tick) |=>
      (!clk_pend && ack_vec == VEC_W'(TIMER_VEC)));

  a_r9_ack_error: assert property (@(posedge clk) disable iff (rst)
    (ack_req && ack_lvl > LVL_W'(LVL_HMAX)) |=> (ack_err && ack_vec == '0));

endmodule

bind ilv_eval ilv_eval_chk #(
  .LVL_W(LVL_W), .VEC_W(VEC_W), .LVL_HALT(LVL_HALT),
  .LVL_CLK(LVL_CLK), .LVL_HMAX(LVL_HMAX), .TIMER_VEC(TIMER_VEC)
) u_chk (
  .clk(clk), .rst(rst), .halt_pin(halt_pin), .clk_tick(clk_tick),
  .clk_pend(clk_pend), .cur_lvl(cur_lvl), .ack_req(ack_req),
  .ack_lvl(ack_lvl), .ack_vec(ack_vec), .ack_err(ack_err),
  .win_lvl(win_lvl)
);

// File: tb/ilv_eval_bench.sv
module ilv_eval_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt_pin = 1'b0, clk_tick = 1'b0;
  logic [3:0]  hw_set = '0;
  logic [15:0] sw_summary = '0;
  logic [4:0]  cur_lvl = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [3:0]  reg_wdata = '0;
  logic [3:0]  reg_rdata;
  logic        vt_wr = 1'b0;
  logic [2:0]  vt_idx = '0;
  logic [15:0] vt_wdata = '0;
  logic        ack_req = 1'b0;
  logic [4:0]  ack_lvl = '0;
  logic [9:0]  ack_vec;
  logic        ack_err;
  logic [4:0]  win_lvl;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ilv_eval u_ilv_eval (
    .clk(clk), .rst(rst), .halt_pin(halt_pin), .clk_tick(clk_tick),
    .hw_set(hw_set), .sw_summary(sw_summary), .cur_lvl(cur_lvl),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vt_wr(vt_wr),
    .vt_idx(vt_idx), .vt_wdata(vt_wdata), .ack_req(ack_req),
    .ack_lvl(ack_lvl), .ack_vec(ack_vec), .ack_err(ack_err),
    .win_lvl(win_lvl)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [9:0] tbl_vec(input int e);
    return 10'(32'h200 + e * 3);
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [3:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    step(); d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse_hw(input logic [3:0] b);
    @(negedge clk); hw_set = b;
    @(negedge clk); hw_set = '0;
  endtask

  task automatic acknowledge(input logic [4:0] l, output logic [9:0] v, output logic e);
    @(negedge clk); ack_req = 1; ack_lvl = l;
    step(); v = ack_vec; e = ack_err;
    @(negedge clk); ack_req = 0;
  endtask

  task automatic level_after(input logic [4:0] c, input logic [15:0] s, output logic [4:0] w);
    @(negedge clk); cur_lvl = c; sw_summary = s;
    step(); w = win_lvl;
  endtask

  task automatic t_reset();
    logic [3:0] d;
    check("R5 reset level", win_lvl, 0);
    reg_read(2'd0, d); check("R6 reset request", d, 0);
    reg_read(2'd1, d); check("R6 reset mask", d, 0);
  endtask

  task automatic t_table();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); vt_wr = 1; vt_idx = 3'(i);
      vt_wdata = {6'b101101, tbl_vec(i)};   // R10 upper bits must be dropped
    end
    @(negedge clk); vt_wr = 0;
  endtask

  task automatic t_halt();
    logic [4:0] w;
    @(negedge clk); halt_pin = 1;
    level_after(5'd31, 16'hFFFF, w); check("R1 halt at max level", w, 31);
    @(negedge clk); halt_pin = 0;
    level_after(5'd0, 16'h0000, w); check("R5 idle level", w, 0);
  endtask

  task automatic t_clock();
    logic [4:0] w; logic [9:0] v; logic e;
    @(negedge clk); clk_tick = 1;
    @(negedge clk); clk_tick = 0;
    level_after(5'd21, 16'h0, w); check("R2 clock above current", w, 22);
    level_after(5'd22, 16'h0, w); check("R2 clock not above current", w, 0);
    level_after(5'd0, 16'h8000, w); check("R11 clock still pending over sw", w, 22);
    acknowledge(5'd22, v, e);
    check("R7 timer vector", v, 'h0C0); check("R7 no error", e, 0);
    level_after(5'd0, 16'h0, w); step(); w = win_lvl;
    check("R7 clock cleared", w, 0);
  endtask

  task automatic t_hw();
    logic [4:0] w; logic [3:0] d; logic [9:0] v; logic e;
    pulse_hw(4'b0101);
    level_after(5'd0, 16'h0, w); check("R3 fully masked", w, 0);
    reg_write(2'd1, 4'b0100);
    level_after(5'd19, 16'h0, w); step(); w = win_lvl;
    check("R3 unmasked hw", w, 20);
    level_after(5'd20, 16'h0, w); check("R3 hw not above current", w, 0);
    level_after(5'd3, 16'h8000, w); check("R3 hw over software", w, 20);
    @(negedge clk); clk_tick = 1;
    @(negedge clk); clk_tick = 0;
    level_after(5'd0, 16'h0, w); check("R2 clock over hw", w, 22);
    acknowledge(5'd22, v, e);
    acknowledge(5'd20, v, e); check("R8 source 2 vector", v, tbl_vec(6));
    reg_write(2'd3, 4'b1111);
    acknowledge(5'd21, v, e); check("R8 source 2 beats 0", v, tbl_vec(6));
    reg_write(2'd2, 4'b0100);
    reg_read(2'd0, d); check("R6 alias clear", d, 4'b0001);
    acknowledge(5'd20, v, e); check("R8 source 0 vector", v, tbl_vec(1));
    pulse_hw(4'b1010);
    acknowledge(5'd20, v, e); check("R8 source 3 vector", v, tbl_vec(7));
    reg_write(2'd2, 4'b1000);
    acknowledge(5'd23, v, e); check("R8 source 1 vector", v, tbl_vec(4));
    reg_write(2'd3, 4'b0000);
    reg_read(2'd1, d); check("R6 mask alias", d, 0);
    acknowledge(5'd20, v, e); check("R8 none unmasked", v, 0);
    // set and clear in the same cycle
    @(negedge clk); hw_set = 4'b0100; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 4'b0110;
    @(negedge clk); hw_set = '0; reg_wr = 0;
    reg_read(2'd0, d); check("R6 set wins over clear", d, 4'b0101);
    reg_write(2'd0, 4'b1111);
    reg_read(2'd2, d); check("R6 cleared all", d, 0);
  endtask

  task automatic t_sw();
    logic [4:0] w;
    level_after(5'd0, 16'h8010, w);  check("R4 highest bit", w, 15);
    level_after(5'd4, 16'h0030, w);  check("R4 just above current", w, 5);
    level_after(5'd5, 16'h0030, w);  check("R4 none above current", w, 0);
    level_after(5'd0, 16'h0001, w);  check("R4 bit 0 ignored", w, 0);
    level_after(5'd15, 16'hFFFF, w); check("R4 at software max", w, 0);
    level_after(5'd14, 16'hFFFF, w); check("R4 below software max", w, 15);
  endtask

  task automatic t_err();
    logic [9:0] v; logic e;
    acknowledge(5'd24, v, e);
    check("R9 error flag", e, 1); check("R9 error vector", v, 0);
    step(); check("R9 error one cycle", ack_err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    t_reset();
    t_table();
    t_halt();
    t_clock();
    t_hw();
    t_sw();
    t_err();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule